// File: doc/BRIEF.md
# Dual Masked Alarm Comparator

This block holds two alarm settings and compares each against the running time of a calendar clock. An alarm is eight bytes at the same offsets as the clock's time bytes. The top bit of each alarm byte says whether that field takes part in the match, and the lower seven bits hold the BCD value to match. Disabled fields always count as matching. Leaving the coarser fields disabled gives a repeating alarm: for example, enabling only seconds and minutes gives an hourly alarm, and enabling month, date and the time of day gives a yearly one.

The compare is evaluated once for each 1 Hz tick, which arrives after the clock bytes have advanced. A match sets a sticky flag in a status byte: alarm 0 sets bit 5 and alarm 1 sets bit 6. A host read of the status byte clears both flags. An active-low interrupt line follows the flags in level mode. In pulse mode it drops for a fixed number of cycles on each new match.

Top module: `dual_alarm_cmp`

## Requirements
- R1: After reset, all sixteen alarm bytes read back as 0x00, the status byte is 0x00 and irq_n is high.
- R2: A write with wr_en high stores wr_data in the byte picked by wr_sel, where bit 3 selects the alarm and bits 2:0 give the byte offset. rd_data shows the byte picked by rd_sel in the same way, on the cycle after the write.
- R3: The compared offsets are 0 (second), 1 (minute), 2 (hour), 3 (date), 4 (month) and 6 (day of week). An alarm byte with bit 7 set is enabled, and its bits 6:0 must equal bits 6:0 of the clock byte at the same offset. A disabled field always matches.
- R4: Bit 7 of the clock bytes, which includes the 24-hour-mode bit of the hour byte, is ignored by the compare.
- R5: An alarm with no enabled compared field never sets its flag.
- R6: The compare only takes effect on a cycle with tick high. A matching time without a tick leaves the flags unchanged.
- R7: A match at a tick sets status bit 5 for alarm 0 and status bit 6 for alarm 1. All other status bits read 0. A set flag stays set through later ticks that do not match.
- R8: stat_rd high for a cycle clears both flags. If a tick with a match arrives in that same cycle, the flag of the matching alarm is set instead.
- R9: With irq_pulse_mode low, irq_n is low exactly while at least one flag is set.
- R10: With irq_pulse_mode high, irq_n goes low for PULSE_LEN cycles after each tick with a match on either alarm, whatever the flags hold.
- R11: Alarm bytes at offsets 5 and 7 are stored and can be read back, but they never count as enabled and never affect a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle 1 Hz strobe, asserted after the clock bytes update |
| now | input | 64 | Current clock bytes; the byte at offset k is at bits 8k+7:8k |
| wr_en | input | 1 | Alarm byte write strobe |
| wr_sel | input | 4 | Write select: bit 3 is the alarm, bits 2:0 are the offset |
| wr_data | input | 8 | Byte to write |
| rd_sel | input | 4 | Readback select, coded like wr_sel |
| rd_data | output | 8 | Selected alarm byte |
| stat_rd | input | 1 | Status read strobe; clears the flags |
| irq_pulse_mode | input | 1 | 0 gives a level interrupt, 1 gives a pulse interrupt |
| status | output | 8 | Status byte: bit 5 is the alarm 0 flag, bit 6 is the alarm 1 flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with PULSE_LEN set to 3, so the start and the end of an interrupt pulse both fall within a few sampled cycles, while the flag stays set after the pulse is over. One alarm is set to repeat every hour and the other to repeat every month. A table of clock values then covers near misses on each field, a set 24-hour bit and a changed year byte. Directed cases cover a tick that meets a status clear, a matching time with no tick, and matches on the day-of-week field alone.

// File: rtl/dual_alarm_cmp.sv
module dual_alarm_cmp #(
  parameter int PULSE_LEN = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic [63:0] now,
  input  logic        wr_en,
  input  logic [3:0]  wr_sel,
  input  logic [7:0]  wr_data,
  input  logic [3:0]  rd_sel,
  output logic [7:0]  rd_data,
  input  logic        stat_rd,
  input  logic        irq_pulse_mode,
  output logic [7:0]  status,
  output logic        irq_n
);
  localparam int NALM = 2;
  localparam int NBYTE = 8;
  localparam int CW = $clog2(PULSE_LEN + 1);
  localparam logic [NBYTE-1:0] CMP_MASK = 8'b0101_1111;

  logic [7:0] regs [NALM][NBYTE];
  logic [NALM-1:0][NBYTE-1:0] fld_en, fld_ok;
  logic [NALM-1:0] hit, flag;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int a = 0; a < NALM; a++)
        for (int b = 0; b < NBYTE; b++) regs[a][b] <= '0;
    end else if (wr_en) begin
      regs[wr_sel[3]][wr_sel[2:0]] <= wr_data;
    end

  assign rd_data = regs[rd_sel[3]][rd_sel[2:0]];

  for (genvar a = 0; a < NALM; a++) begin : g_alm
    for (genvar b = 0; b < NBYTE; b++) begin : g_fld
      assign fld_en[a][b] = CMP_MASK[b] & regs[a][b][7];
      assign fld_ok[a][b] = !fld_en[a][b] || (regs[a][b][6:0] == now[8*b +: 7]);
    end
    assign hit[a] = (|fld_en[a]) && (&fld_ok[a]);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) flag[a] <= 1'b0;
      else if (tick && hit[a]) flag[a] <= 1'b1;
      else if (stat_rd) flag[a] <= 1'b0;

    assert_set_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[a]) |-> $past(tick));
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[a] && !stat_rd) |=> flag[a]);
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !tick) |=> !flag[a]);
    assert_no_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !flag[a] && (fld_en[a] == '0)) |=> !flag[a]);
  end

  assign status = {1'b0, flag[1], flag[0], 5'b0};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else if (tick && |hit) cnt <= CW'(PULSE_LEN);
    else if (cnt != '0) cnt <= cnt - 1'b1;

  assign irq_n = irq_pulse_mode ? (cnt == '0) : !(|flag);

  assert_pulse_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse_mode && tick && |hit) |=> (!irq_n || !irq_pulse_mode));
endmodule

// File: tb/dual_alarm_cmp_tb_top.sv
module dual_alarm_cmp_tb_top;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0, stat_rd = 0, irq_pulse_mode = 0;
  logic [63:0] now = '0;
  logic [3:0] wr_sel = '0, rd_sel = '0;
  logic [7:0] wr_data = '0, rd_data, status;
  logic irq_n;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  dual_alarm_cmp #(.PULSE_LEN(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .now(now), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .stat_rd(stat_rd), .irq_pulse_mode(irq_pulse_mode), .status(status), .irq_n(irq_n));

  localparam int NV = 9;
  localparam logic [65:0] VEC [NV] = '{
    {2'b01, 64'h20_03_24_01_05_10_15_30},
    {2'b00, 64'h20_03_24_01_05_10_15_31},
    {2'b00, 64'h20_03_24_01_05_10_16_30},
    {2'b01, 64'h20_05_24_12_12_A3_15_30},
    {2'b10, 64'h20_02_24_03_01_00_00_00},
    {2'b10, 64'h20_02_99_03_01_80_00_00},
    {2'b00, 64'h20_02_24_03_01_01_00_00},
    {2'b01, 64'h20_02_24_03_01_00_15_30},
    {2'b00, 64'h20_02_24_03_02_00_00_00}
  };

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] s, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic clr();
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 status", status, 8'h00);
    chk("R1 irq_n", irq_n, 1'b1);
    for (int i = 0; i < 16; i++) begin
      rd_sel = 4'(i); #1;
      chk("R1 readback", rd_data, 8'h00);
    end
    do_tick();
    chk("R5 nothing enabled", status, 8'h00);

    wr(4'h0, 8'hB0); wr(4'h1, 8'h95);
    wr(4'h8, 8'h80); wr(4'h9, 8'h80); wr(4'hA, 8'h80); wr(4'hB, 8'h81);
    rd_sel = 4'h1; #1; chk("R2 readback a0 min", rd_data, 8'h95);
    rd_sel = 4'hB; #1; chk("R2 readback a1 date", rd_data, 8'h81);

    for (int i = 0; i < NV; i++) begin
      now = VEC[i][63:0];
      do_tick();
      chk("R3 R4 R7 table flags", status, {1'b0, VEC[i][65:64], 5'b0});
      chk("R9 table irq level", irq_n, !(|VEC[i][65:64]));
      clr();
      chk("R8 cleared", status, 8'h00);
    end

    now = 64'h20_03_24_01_05_10_15_30;
    repeat (4) @(negedge clk);
    chk("R6 no tick no flag", status, 8'h00);

    do_tick();
    now = 64'h20_03_24_01_05_10_15_31;
    do_tick();
    chk("R7 sticky", status, 8'h20);
    chk("R9 level low", irq_n, 1'b0);
    clr();
    chk("R9 level released", irq_n, 1'b1);

    now = 64'h20_03_24_01_05_10_15_30;
    @(negedge clk); tick = 1; stat_rd = 1;
    @(negedge clk); tick = 0; stat_rd = 0;
    chk("R8 set wins over clear", status, 8'h20);
    clr();

    irq_pulse_mode = 1;
    do_tick();
    chk("R10 pulse cycle 1", irq_n, 1'b0);
    @(negedge clk); chk("R10 pulse cycle 2", irq_n, 1'b0);
    @(negedge clk); chk("R10 pulse cycle 3", irq_n, 1'b0);
    @(negedge clk); chk("R10 pulse ended", irq_n, 1'b1);
    chk("R10 flag still held", status, 8'h20);
    clr();
    irq_pulse_mode = 0;

    for (int b = 8; b < 16; b++) wr(4'(b), 8'h00);
    wr(4'hE, 8'h83);
    now = 64'h20_03_24_01_05_10_15_31;
    do_tick();
    chk("R3 weekday offset 6 match", status, 8'h40);
    clr();
    now = 64'h20_04_24_01_05_10_15_31;
    do_tick();
    chk("R3 weekday mismatch", status, 8'h00);

    wr(4'hE, 8'h00); wr(4'hD, 8'hA4); wr(4'hF, 8'hA0);
    rd_sel = 4'hD; #1; chk("R11 byte5 stored", rd_data, 8'hA4);
    rd_sel = 4'hF; #1; chk("R11 byte7 stored", rd_data, 8'hA0);
    now = 64'h20_04_24_01_05_10_15_31;
    do_tick();
    chk("R11 bytes 5 and 7 ignored", status, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule